// File: doc/BRIEF.md
# Image Port Output Formatter

The formatter takes 32-bit Dwords from two upstream queues and sends them out on one narrow output port. One queue holds scaled video. The other holds sliced VBI payload, and each VBI line is closed by a Dword marked as last. In wide mode each Dword goes out as two 16-bit words. In narrow mode it goes out as four bytes on the low lane. A data-valid qualifier marks every cycle that carries payload, because the output stream has gaps whenever the sources run dry.

A fixed-priority arbiter picks the next Dword only at a Dword boundary. VBI data wins over video. Once a VBI line has started, no other source may cut into it until its last Dword has been sent.

For receivers with few pins there are two options. The qualifier can be turned into a gated clock. In narrow mode, field, vertical and horizontal timing can be sent in-band as a four-byte code of preamble plus status word. The payload is then clipped so that it never imitates a preamble. A VBI flag output marks the beats that carry VBI payload. The field, vertical and horizontal inputs are also passed through, registered, as reference outputs.

Top module: `img_port_fmt`

## Requirements
- R1: In narrow mode (`wide_i`=0), each Dword goes out as four bytes on `data_o[7:0]` in the order bits 7:0, 15:8, 23:16, 31:24, and `data_o[15:8]` stays zero.
- R2: In wide mode (`wide_i`=1), each Dword goes out as two words: bits 15:0 first, then bits 31:16. The odd bytes (luma) land on `data_o[15:8]` and the even bytes (chroma) on `data_o[7:0]`.
- R3: With the qualifier in normal mode, `dq_o` is high exactly on cycles that carry a beat, and `data_o` is zero on all other cycles. Dwords that are ready back to back go out with no idle cycle between them.
- R4: With `gate_dq_i`=1, `dq_o` follows the beat-valid state only while `clk_i` is low and is held low while `clk_i` is high. Data timing does not change.
- R5: When both sources offer a Dword at a boundary outside a VBI line, the VBI Dword is taken first. Video is never taken while `vbi_valid_i` is high.
- R6: After a VBI Dword without `vbi_last_i` has been accepted, only VBI data may follow, even if VBI stalls and video waits, until the Dword marked last has been accepted. `vbi_flag_o` is high on exactly the beats of VBI Dwords.
- R7: A code request can be taken when embedding is on in narrow mode. A pulse on `code_req_i` captures F, V and H from `sync_f_i`, `sync_v_i` and `sync_h_i`. At the next Dword boundary outside a VBI line, the bytes 0xFF, 0x00, 0x00, XY are sent ahead of any waiting VBI or video data. XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}.
- R8: With embedding on in narrow mode, payload bytes of 0x00 go out as 0x01 and payload bytes of 0xFF go out as 0xFE. Code bytes are sent unchanged.
- R9: Code requests are ignored and payload is not clipped when `embed_i`=0 or `wide_i`=1.
- R10: `ref_o` = {F, V, H} shows the sync inputs one clock after they are sampled.
- R11: During and right after reset, `dq_o`, `data_o`, `vbi_flag_o`, `ref_o` and both ready outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 16-bit words, 0: bytes on low lane |
| embed_i | input | 1 | Insert timing codes and clip payload (narrow mode only) |
| gate_dq_i | input | 1 | Drive qualifier as gated clock |
| vid_valid_i | input | 1 | Video Dword available |
| vid_data_i | input | 32 | Video Dword |
| vid_ready_o | output | 1 | Video Dword taken this cycle |
| vbi_valid_i | input | 1 | VBI Dword available |
| vbi_data_i | input | 32 | VBI Dword |
| vbi_last_i | input | 1 | VBI Dword closes its line |
| vbi_ready_o | output | 1 | VBI Dword taken this cycle |
| sync_f_i | input | 1 | Field bit |
| sync_v_i | input | 1 | Vertical blanking bit |
| sync_h_i | input | 1 | Horizontal timing bit |
| code_req_i | input | 1 | Request one timing code insertion |
| data_o | output | 16 | Output data lanes |
| dq_o | output | 1 | Data qualifier or gated clock |
| vbi_flag_o | output | 1 | Current beat carries VBI data |
| ref_o | output | 3 | Registered {F, V, H} |

## Verification
The bench builds the block with its default parameters: four bytes per Dword and eight bits per byte. These defaults make the beat counter two bits wide and give a two-entry word select in wide mode, so every lane mapping, clipping value and code byte can be compared against a hand-computed value. The directed scenarios cover several cases. Both sources are preloaded before release to check priority. A VBI line stalls between its Dwords while video waits. A code request is made inside a VBI line, and another in each mode that must ignore it. The gated qualifier is sampled in both clock phases.

// File: rtl/ip_fmt_pkg.sv
package ip_fmt_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_VID  = 2'd1,
    SRC_VBI  = 2'd2,
    SRC_CODE = 2'd3
  } src_e;

  // status word with protection bits
  function automatic logic [7:0] xy_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/ip_fmt_code.sv
module ip_fmt_code import ip_fmt_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       req_i,
  input  logic       f_i,
  input  logic       v_i,
  input  logic       h_i,
  input  logic       take_i,
  output logic       pend_o,
  output logic [7:0] xy_o
);
  logic       pend_q;
  logic [7:0] xy_q;
  logic       req_eff;

  assign req_eff = en_i && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      xy_q   <= 8'h80;
    end else if (req_eff) begin
      pend_q <= 1'b1;
      xy_q   <= xy_word(f_i, v_i, h_i);
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign xy_o   = xy_q;

  // R7: a served code leaves nothing pending
  a_r7_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !req_eff) |=> !pend_o);
  // R7: status word always carries its fixed top bit
  a_r7_xy_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> xy_o[7]);
endmodule

// File: rtl/ip_fmt_arb.sv
module ip_fmt_arb import ip_fmt_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic can_load_i,
  input  logic code_pend_i,
  input  logic vbi_valid_i,
  input  logic vbi_last_i,
  input  logic vid_valid_i,
  output src_e sel_o,
  output logic vid_ready_o,
  output logic vbi_ready_o,
  output logic code_take_o
);
  logic in_blk_q;

  always_comb begin
    sel_o = SRC_NONE;
    if (can_load_i) begin
      if (in_blk_q)         sel_o = vbi_valid_i ? SRC_VBI : SRC_NONE;
      else if (code_pend_i) sel_o = SRC_CODE;
      else if (vbi_valid_i) sel_o = SRC_VBI;
      else if (vid_valid_i) sel_o = SRC_VID;
    end
  end

  assign vid_ready_o = (sel_o == SRC_VID);
  assign vbi_ready_o = (sel_o == SRC_VBI);
  assign code_take_o = (sel_o == SRC_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          in_blk_q <= 1'b0;
    else if (vbi_ready_o) in_blk_q <= !vbi_last_i;
  end

  // R6: an open VBI line locks out video on the next cycle
  a_r6_line_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbi_ready_o && !vbi_last_i) |=> !vid_ready_o);
  // R6: the line closes once its last Dword is taken
  a_r6_line_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbi_ready_o && vbi_last_i) |=> !in_blk_q);
  a_r5_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vid_ready_o, vbi_ready_o, code_take_o}));
endmodule

// File: rtl/ip_fmt_ser.sv
module ip_fmt_ser import ip_fmt_pkg::*; #(
  parameter  int BYTES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DW     = BYTES * BYTE_W,
  localparam int PW     = 2 * BYTE_W,
  localparam int WORDS  = BYTES / 2,
  localparam int BW     = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          clip_en_i,
  input  src_e          src_i,
  input  logic [DW-1:0] data_i,
  output logic          can_load_o,
  output logic          busy_o,
  output logic          vbi_o,
  output logic [PW-1:0] data_o
);
  logic          busy_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] last_beat;
  src_e          src_q;
  logic [DW-1:0] dw_q;
  logic          at_last;
  logic          take;
  logic          clip_q;

  assign last_beat  = wide_i ? BW'(WORDS - 1) : BW'(BYTES - 1);
  assign at_last    = busy_q && (beat_q == last_beat);
  assign can_load_o = !busy_q || at_last;
  assign take       = can_load_o && (src_i != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      src_q  <= SRC_NONE;
      dw_q   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      src_q  <= src_i;
      dw_q   <= data_i;
    end else if (at_last) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (busy_q) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign clip_q = clip_en_i && (src_q != SRC_CODE);

  logic [BYTE_W-1:0] byte_c [BYTES];
  logic [PW-1:0]     word_c [WORDS];

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic [BYTE_W-1:0] raw;
    assign raw       = dw_q[k*BYTE_W +: BYTE_W];
    // keep payload clear of code preambles
    assign byte_c[k] = !clip_q       ? raw :
                       (raw == '0)   ? BYTE_W'(1) :
                       (raw == '1)   ? ~BYTE_W'(1) : raw;
  end

  for (genvar j = 0; j < WORDS; j++) begin : g_word
    assign word_c[j] = {byte_c[2*j+1], byte_c[2*j]};
  end

  always_comb begin
    if (!busy_q)     data_o = '0;
    else if (wide_i) data_o = word_c[beat_q[BW-2:0]];
    else             data_o = {{BYTE_W{1'b0}}, byte_c[beat_q]};
  end

  assign busy_o = busy_q;
  assign vbi_o  = busy_q && (src_q == SRC_VBI);

  // R3: beats advance one per cycle within a Dword
  a_r3_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !at_last) |=> (busy_q && beat_q == $past(beat_q) + 1'b1));
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (data_o == '0));
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && busy_q) |-> (data_o[PW-1:BYTE_W] == '0));
  a_r8_no_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip_q && busy_q && !wide_i) |->
      (data_o[BYTE_W-1:0] != '0 && data_o[BYTE_W-1:0] != '1));
endmodule

// File: rtl/img_port_fmt.sv
module img_port_fmt import ip_fmt_pkg::*; #(
  parameter  int BYTES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DW     = BYTES * BYTE_W,
  localparam int PW     = 2 * BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          embed_i,
  input  logic          gate_dq_i,
  input  logic          vid_valid_i,
  input  logic [DW-1:0] vid_data_i,
  output logic          vid_ready_o,
  input  logic          vbi_valid_i,
  input  logic [DW-1:0] vbi_data_i,
  input  logic          vbi_last_i,
  output logic          vbi_ready_o,
  input  logic          sync_f_i,
  input  logic          sync_v_i,
  input  logic          sync_h_i,
  input  logic          code_req_i,
  output logic [PW-1:0] data_o,
  output logic          dq_o,
  output logic          vbi_flag_o,
  output logic [2:0]    ref_o
);
  logic          embed_on;
  logic          can_load;
  logic          busy;
  logic          code_pend;
  logic          code_take;
  logic [7:0]    xy;
  src_e          sel;
  logic [DW-1:0] code_dw;
  logic [DW-1:0] load_dw;
  logic [2:0]    ref_q;

  assign embed_on = embed_i && !wide_i;

  ip_fmt_code u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (embed_on),
    .req_i  (code_req_i),
    .f_i    (sync_f_i),
    .v_i    (sync_v_i),
    .h_i    (sync_h_i),
    .take_i (code_take),
    .pend_o (code_pend),
    .xy_o   (xy)
  );

  ip_fmt_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .can_load_i  (can_load),
    .code_pend_i (code_pend),
    .vbi_valid_i (vbi_valid_i),
    .vbi_last_i  (vbi_last_i),
    .vid_valid_i (vid_valid_i),
    .sel_o       (sel),
    .vid_ready_o (vid_ready_o),
    .vbi_ready_o (vbi_ready_o),
    .code_take_o (code_take)
  );

  // preamble in the first byte, status word in the last
  assign code_dw = {BYTE_W'(xy), {(DW - 2*BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  always_comb begin
    unique case (sel)
      SRC_VBI:  load_dw = vbi_data_i;
      SRC_CODE: load_dw = code_dw;
      SRC_VID:  load_dw = vid_data_i;
      default:  load_dw = '0;
    endcase
  end

  ip_fmt_ser #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_i     (wide_i),
    .clip_en_i  (embed_on),
    .src_i      (sel),
    .data_i     (load_dw),
    .can_load_o (can_load),
    .busy_o     (busy),
    .vbi_o      (vbi_flag_o),
    .data_o     (data_o)
  );

  // gated form: pulse in the low phase of beat cycles
  assign dq_o = gate_dq_i ? (busy && !clk_i) : busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= {sync_f_i, sync_v_i, sync_h_i};
  end
  assign ref_o = ref_q;

  // R5: video never taken while VBI is offered
  a_r5_vbi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_ready_o |-> !vbi_valid_i);
  // R10: reference outputs trail the sync inputs by one clock
  a_r10_ref_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ref_o == $past({sync_f_i, sync_v_i, sync_h_i})));
endmodule

// File: tb/img_port_fmt_tb.sv
`timescale 1ns/1ps
module img_port_fmt_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wide = 1'b0, embed = 1'b0, gate = 1'b0;
  logic        sf = 1'b0, sv = 1'b0, sh = 1'b0, creq = 1'b0;
  logic        vid_valid, vid_ready, vbi_valid, vbi_ready, vbi_last;
  logic [31:0] vid_data, vbi_data;
  logic [15:0] data;
  logic        dq, vbi_flag;
  logic [2:0]  refs;

  // source queues
  logic [31:0] vid_mem [16];
  logic [31:0] vbi_mem [16];
  logic        vbi_lm  [16];
  int          vid_n = 0, vbi_n = 0, vid_idx = 0, vbi_idx = 0;
  logic        go = 1'b0, src_clr = 1'b0;

  assign vid_valid = go && (vid_idx < vid_n);
  assign vbi_valid = go && (vbi_idx < vbi_n);
  assign vid_data  = vid_mem[vid_idx[3:0]];
  assign vbi_data  = vbi_mem[vbi_idx[3:0]];
  assign vbi_last  = vbi_lm[vbi_idx[3:0]];

  always @(posedge clk) begin
    if (src_clr) begin
      vid_idx <= 0;
      vbi_idx <= 0;
    end else begin
      if (vid_ready) vid_idx <= vid_idx + 1;
      if (vbi_ready) vbi_idx <= vbi_idx + 1;
    end
  end

  img_port_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .embed_i(embed), .gate_dq_i(gate),
    .vid_valid_i(vid_valid), .vid_data_i(vid_data), .vid_ready_o(vid_ready),
    .vbi_valid_i(vbi_valid), .vbi_data_i(vbi_data), .vbi_last_i(vbi_last),
    .vbi_ready_o(vbi_ready), .sync_f_i(sf), .sync_v_i(sv), .sync_h_i(sh),
    .code_req_i(creq), .data_o(data), .dq_o(dq), .vbi_flag_o(vbi_flag), .ref_o(refs)
  );

  // capture monitor, low clock phase
  logic [15:0] cap_d [64];
  logic        cap_f [64];
  int          cap_c [64];
  int          cap_n = 0, cyc = 0;
  logic        cap_clr = 1'b0;
  int          errs = 0, checks = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (cap_clr) cap_n = 0;
    else if (dq && cap_n < 64) begin
      cap_d[cap_n] = data;
      cap_f[cap_n] = vbi_flag;
      cap_c[cap_n] = cyc;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog: act=%0d exp<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input int i, input logic [15:0] d, input logic f, input string tag);
    if (i >= cap_n) chk(1'b0, {tag, " missing beat"}, cap_n, i + 1);
    else chk(cap_d[i] == d && cap_f[i] == f, tag, {15'd0, cap_f[i], cap_d[i]}, {15'd0, f, d});
  endtask

  task automatic prep();
    @(negedge clk);
    go = 1'b0; src_clr = 1'b1; cap_clr = 1'b1; vid_n = 0; vbi_n = 0;
    @(negedge clk);
    src_clr = 1'b0; cap_clr = 1'b0;
  endtask

  task automatic code_pulse(input logic f, input logic v, input logic h);
    @(negedge clk);
    sf = f; sv = v; sh = h; creq = 1'b1;
    @(negedge clk);
    creq = 1'b0;
  endtask

  task automatic t_reset();
    chk(dq == 0 && data == 0 && vbi_flag == 0 && refs == 0, "R11 reset outputs",
        {12'd0, dq, vbi_flag, refs, data}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq == 0 && data == 0 && vid_ready == 0 && vbi_ready == 0, "R11 after reset",
        {14'd0, vid_ready, vbi_ready, data}, 0);
  endtask

  task automatic t_wide();
    wide = 1; embed = 0; gate = 0;
    prep();
    vid_mem[0] = 32'h11223344; vid_mem[1] = 32'h55667788; vid_mem[2] = 32'h99AABBCC;
    vid_n = 3; go = 1;
    repeat (14) @(negedge clk);
    beat(0, 16'h3344, 0, "R2 word0"); beat(1, 16'h1122, 0, "R2 word1");
    beat(2, 16'h7788, 0, "R2 word2"); beat(3, 16'h5566, 0, "R2 word3");
    beat(4, 16'hBBCC, 0, "R2 word4"); beat(5, 16'h99AA, 0, "R2 word5");
    chk(cap_n == 6, "R3 beat count", cap_n, 6);
    for (int i = 1; i < 6; i++)
      chk(cap_c[i] == cap_c[i-1] + 1, "R3 back to back", cap_c[i] - cap_c[i-1], 1);
    chk(dq == 0 && data == 0, "R3 idle quiet", {15'd0, dq, data}, 0);
  endtask

  task automatic t_narrow();
    wide = 0; embed = 0;
    prep();
    vid_mem[0] = 32'hFF00A5C3; vid_mem[1] = 32'h01020304;
    vid_n = 2; go = 1;
    repeat (14) @(negedge clk);
    beat(0, 16'h00C3, 0, "R1 byte0"); beat(1, 16'h00A5, 0, "R1 byte1");
    beat(2, 16'h0000, 0, "R1 byte2 no clip"); beat(3, 16'h00FF, 0, "R1 byte3 no clip");
    beat(4, 16'h0004, 0, "R1 byte4"); beat(7, 16'h0001, 0, "R1 byte7");
    chk(cap_n == 8, "R1 byte count", cap_n, 8);
  endtask

  task automatic t_prio();
    wide = 0; embed = 0;
    prep();
    vbi_mem[0] = 32'hA0A1A2A3; vbi_lm[0] = 0;
    vbi_mem[1] = 32'hB0B1B2B3; vbi_lm[1] = 1;
    vid_mem[0] = 32'hC0C1C2C3;
    vbi_n = 2; vid_n = 1; go = 1;
    repeat (18) @(negedge clk);
    beat(0, 16'h00A3, 1, "R5 vbi first"); beat(3, 16'h00A0, 1, "R6 vbi flag");
    beat(4, 16'h00B3, 1, "R6 vbi second"); beat(7, 16'h00B0, 1, "R6 vbi end");
    beat(8, 16'h00C3, 0, "R5 video after"); beat(11, 16'h00C0, 0, "R6 flag low video");
  endtask

  task automatic t_block();
    wide = 1; embed = 0;
    prep();
    vbi_mem[0] = 32'hD0D1D2D3; vbi_lm[0] = 0;
    vid_mem[0] = 32'hE0E1E2E3;
    vbi_n = 1; vid_n = 1; go = 1;
    repeat (12) @(negedge clk);
    chk(cap_n == 2, "R6 stalled line holds video", cap_n, 2);
    vbi_mem[1] = 32'hF0F1F2F3; vbi_lm[1] = 1; vbi_n = 2;
    repeat (10) @(negedge clk);
    beat(0, 16'hD2D3, 1, "R6 line dword0"); beat(1, 16'hD0D1, 1, "R6 line dword0 hi");
    beat(2, 16'hF2F3, 1, "R6 line dword1"); beat(3, 16'hF0F1, 1, "R6 line dword1 hi");
    beat(4, 16'hE2E3, 0, "R6 video after line"); beat(5, 16'hE0E1, 0, "R6 video hi");
  endtask

  task automatic t_embed();
    wide = 0; embed = 1;
    prep();
    code_pulse(0, 0, 1);
    vid_mem[0] = 32'hFF007F00; vid_n = 1; go = 1;
    repeat (12) @(negedge clk);
    beat(0, 16'h00FF, 0, "R7 preamble ff"); beat(1, 16'h0000, 0, "R7 preamble 00");
    beat(2, 16'h0000, 0, "R7 preamble 00b"); beat(3, 16'h009D, 0, "R7 xy h=1");
    beat(4, 16'h0001, 0, "R8 clip 00"); beat(5, 16'h007F, 0, "R8 pass");
    beat(6, 16'h0001, 0, "R8 clip 00b"); beat(7, 16'h00FE, 0, "R8 clip ff");
    prep();
    vbi_mem[0] = 32'h11FF2200; vbi_lm[0] = 0; vbi_n = 1; go = 1;
    wait (cap_n >= 1);
    code_pulse(1, 1, 1);
    repeat (6) @(negedge clk);
    vbi_mem[1] = 32'h33333333; vbi_lm[1] = 1; vbi_n = 2;
    repeat (14) @(negedge clk);
    beat(0, 16'h0001, 1, "R8 vbi clip 00"); beat(2, 16'h00FE, 1, "R8 vbi clip ff");
    beat(4, 16'h0033, 1, "R7 code waits for line"); beat(7, 16'h0033, 1, "R7 line end");
    beat(8, 16'h00FF, 0, "R7 code after line"); beat(11, 16'h00F1, 0, "R7 xy fvh=111");
    chk(cap_n == 12, "R7 total beats", cap_n, 12);
  endtask

  task automatic t_ignore();
    wide = 1; embed = 1;
    prep();
    code_pulse(0, 1, 0);
    repeat (8) @(negedge clk);
    chk(cap_n == 0, "R9 code ignored wide", cap_n, 0);
    vid_mem[0] = 32'h00FF0000; vid_n = 1; go = 1;
    repeat (8) @(negedge clk);
    beat(0, 16'h0000, 0, "R9 no clip wide lo"); beat(1, 16'h00FF, 0, "R9 no clip wide hi");
    chk(cap_n == 2, "R9 no code in wide", cap_n, 2);
    wide = 0; embed = 0;
    prep();
    code_pulse(1, 0, 0);
    repeat (8) @(negedge clk);
    chk(cap_n == 0, "R9 code ignored embed off", cap_n, 0);
  endtask

  task automatic t_gate();
    wide = 0; embed = 0; gate = 1;
    prep();
    vid_mem[0] = 32'h12345678; vid_n = 1; go = 1;
    wait (cap_n >= 1);
    @(posedge clk); #1;
    chk(dq == 0 && data == 16'h0056, "R4 high phase gated", {15'd0, dq, data}, 32'h56);
    repeat (8) @(negedge clk);
    beat(0, 16'h0078, 0, "R4 gated byte0"); beat(3, 16'h0012, 0, "R4 gated byte3");
    chk(cap_n == 4, "R4 gated pulses", cap_n, 4);
    gate = 0;
  endtask

  task automatic t_ref();
    @(negedge clk);
    sf = 1; sv = 0; sh = 1;
    @(posedge clk); #1;
    chk(refs == 3'b101, "R10 ref fvh", refs, 3'b101);
    @(negedge clk);
    sf = 0; sv = 1; sh = 0;
    @(posedge clk); #1;
    chk(refs == 3'b010, "R10 ref fvh 2", refs, 3'b010);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      vid_mem[i] = '0; vbi_mem[i] = '0; vbi_lm[i] = 1'b0;
    end
    #1;
    t_reset();
    t_wide();
    t_narrow();
    t_prio();
    t_block();
    t_embed();
    t_ignore();
    t_gate();
    t_ref();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule